// File: doc/BRIEF.md
# Lock-Gated Indirect Register Window Slave

This block is a slave on a device control register (DCR) bus with a 10-bit address space and 32-bit data. It opens three indirect windows onto three small internal register files. Each window is a pair of addresses: an index register that selects an entry, and a data register through which that entry is read or written. Software first writes the index, then reads or writes the data address.

The third window is guarded by a key register. The key holds one of two fixed constants. Any non-zero write to the key flips it to the other constant, and a write of zero leaves it unchanged. The guarded window's data path works only while the key holds its open constant. Every address that is not decoded reads as zero and ignores writes.

Accesses take one bus cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `dcr_window_slave`

## Requirements
- R1: After reset the key reads 0x49424D11 (locked), every index register reads 0, every file entry reads 0, and `dcr_rdata` is 0.
- R2: Window A uses index address 0x010 and data address 0x011. A write to 0x010 stores the index, and a read of 0x010 returns it zero-extended. Reads and writes of 0x011 reach entry `index` of file A.
- R3: Window B uses index address 0x016 and data address 0x017. It behaves like window A on its own file and its own index, and it is independent of the other windows.
- R4: Window C uses index address 0x021 and data address 0x022. While the key equals 0x49424D10 (open), data accesses reach entry `index` of file C.
- R5: A read of address 0x020 returns the key. A write of any non-zero value to 0x020 toggles the key between 0x49424D10 and 0x49424D11. A write of zero leaves the key unchanged.
- R6: While the key equals 0x49424D11 (locked), a read of 0x022 returns 0 and a write to 0x022 leaves file C unchanged. The index at 0x021 stays readable and writable.
- R7: Any address other than 0x010, 0x011, 0x016, 0x017, 0x020, 0x021 and 0x022 reads as 0, and a write to it changes no state.
- R8: Read data appears on `dcr_rdata` in the cycle after the read strobe. In any cycle that follows a cycle with no read strobe, `dcr_rdata` is 0.
- R9: When a read and a write hit the same address in the same cycle, the read returns the value held before that write.
- R10: Each file has 16 entries. Only the low 4 bits of an index write are kept, so writing 0x13 selects entry 3 and reads back as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block. |
| dcr_addr | input | 10 | Register address |
| dcr_rd | input | 1 | Read strobe |
| dcr_wr | input | 1 | Write strobe |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Registered read data |

## Verification
On every cycle, the bound checker confirms four things. The key always holds one of its two constants. It toggles exactly when a non-zero value is written to it. Read data is zero after idle cycles and after reads of unmapped addresses. The locked data address always reads zero.

Only the bench scenarios can show some behaviours:
- routing through each index to the right entry;
- independence of the three files;
- index truncation;
- writes to the guarded window being dropped while it is locked;
- read-before-write ordering on a shared address.

The bench does this by comparing every cycle against a behavioural model.

// File: rtl/dcr_win_pkg.sv
package dcr_win_pkg;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int ENTRIES = 16;
  localparam int NWIN = 3;
  localparam logic [DW-1:0] KEY_OPEN = 32'h49424D10;
  localparam logic [DW-1:0] KEY_SHUT = 32'h49424D11;
  localparam logic [AW-1:0] KEY_ADDR = 10'h020;
  // index/data address pairs, window 0 in the low slice
  localparam logic [NWIN*AW-1:0] IDX_ADDRS = {10'h021, 10'h016, 10'h010};
  localparam logic [NWIN*AW-1:0] DAT_ADDRS = {10'h022, 10'h017, 10'h011};
  localparam logic [NWIN-1:0]    WIN_GATED = 3'b100;
endpackage

// File: rtl/dcr_win_rst_sync.sv
module dcr_win_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcr_win_key.sv
module dcr_win_key #(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   OPEN = '0,
  parameter logic [DW-1:0]   SHUT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_wdata,
  output logic [DW-1:0] key_q,
  output logic          unlocked
);
  logic          flip_en;
  logic [DW-1:0] key_d;

  always_comb begin
    flip_en = key_wr && (key_wdata != '0);
    key_d   = key_q;
    if (flip_en) key_d = (key_q == OPEN) ? SHUT : OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= SHUT;
    else if (flip_en) key_q <= key_d;
  end

  assign unlocked = (key_q == OPEN);
endmodule

// File: rtl/dcr_win_regfile.sv
module dcr_win_regfile #(
  parameter int            AW       = 10,
  parameter int            DW       = 32,
  parameter int            ENTRIES  = 16,
  parameter logic [AW-1:0] IDX_ADDR = '0,
  parameter logic [AW-1:0] DAT_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          enable,
  output logic          rd_hit,
  output logic [DW-1:0] rd_val
);
  localparam int IW = $clog2(ENTRIES);

  logic          hit_idx;
  logic          hit_dat;
  logic          idx_en;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic [DW-1:0] mem_q [ENTRIES];

  always_comb begin
    hit_idx = (bus_addr == IDX_ADDR);
    hit_dat = (bus_addr == DAT_ADDR);
    idx_en  = bus_wr && hit_idx;
    idx_d   = bus_wdata[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wen;
    always_comb wen = bus_wr && hit_dat && enable && (idx_q == IW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[e] <= '0;
      else if (wen) mem_q[e] <= bus_wdata;
    end
  end

  always_comb begin
    rd_hit = hit_idx || hit_dat;
    rd_val = '0;
    if (hit_idx)             rd_val = {{(DW-IW){1'b0}}, idx_q};
    else if (hit_dat && enable) rd_val = mem_q[idx_q];
  end
endmodule

// File: rtl/dcr_window_slave.sv
module dcr_window_slave
  import dcr_win_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dcr_addr,
  input  logic          dcr_rd,
  input  logic          dcr_wr,
  input  logic [DW-1:0] dcr_wdata,
  output logic [DW-1:0] dcr_rdata
);
  logic          srst_n;
  logic [DW-1:0] key_q;
  logic          unlocked;
  logic          key_hit;
  logic [NWIN-1:0] win_hit;
  logic [DW-1:0] win_val [NWIN];
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_d;

  dcr_win_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  assign key_hit = (dcr_addr == KEY_ADDR);

  dcr_win_key #(.DW(DW), .OPEN(KEY_OPEN), .SHUT(KEY_SHUT)) u_key (
    .clk(clk), .rst_n(srst_n),
    .key_wr(dcr_wr && key_hit), .key_wdata(dcr_wdata),
    .key_q(key_q), .unlocked(unlocked)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic gate_ok;
    if (WIN_GATED[w]) begin : g_gated
      assign gate_ok = unlocked;
    end else begin : g_open
      assign gate_ok = 1'b1;
    end
    dcr_win_regfile #(
      .AW(AW), .DW(DW), .ENTRIES(ENTRIES),
      .IDX_ADDR(IDX_ADDRS[w*AW +: AW]),
      .DAT_ADDR(DAT_ADDRS[w*AW +: AW])
    ) u_rf (
      .clk(clk), .rst_n(srst_n),
      .bus_addr(dcr_addr), .bus_wr(dcr_wr), .bus_wdata(dcr_wdata),
      .enable(gate_ok),
      .rd_hit(win_hit[w]), .rd_val(win_val[w])
    );
  end

  always_comb begin
    rd_mux = key_hit ? key_q : '0;
    for (int w = 0; w < NWIN; w++) begin
      rd_mux = rd_mux | (win_val[w] & {DW{win_hit[w]}});
    end
    rdata_d = dcr_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) dcr_rdata <= '0;
    else         dcr_rdata <= rdata_d;
  end
endmodule

// File: rtl/dcr_window_slave_chk.sv
module dcr_window_slave_chk
  import dcr_win_pkg::*;
(
  input logic          clk,
  input logic          srst_n,
  input logic [AW-1:0] dcr_addr,
  input logic          dcr_rd,
  input logic          dcr_wr,
  input logic [DW-1:0] dcr_wdata,
  input logic [DW-1:0] dcr_rdata,
  input logic [DW-1:0] key_q
);
  logic mapped;
  always_comb mapped = (dcr_addr == 10'h010) || (dcr_addr == 10'h011) ||
                       (dcr_addr == 10'h016) || (dcr_addr == 10'h017) ||
                       (dcr_addr == 10'h020) || (dcr_addr == 10'h021) ||
                       (dcr_addr == 10'h022);

  // R5
  key_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (key_q == KEY_OPEN) || (key_q == KEY_SHUT));

  // R5
  key_toggle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dcr_wr && dcr_addr == KEY_ADDR && dcr_wdata != '0) |=> (key_q != $past(key_q)));

  // R5
  key_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(dcr_wr && dcr_addr == KEY_ADDR && dcr_wdata != '0) |=> $stable(key_q));

  // R8
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !dcr_rd |=> (dcr_rdata == '0));

  // R7
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dcr_rd && !mapped) |=> (dcr_rdata == '0));

  // R6
  locked_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dcr_rd && dcr_addr == 10'h022 && key_q == KEY_SHUT) |=> (dcr_rdata == '0));
endmodule

bind dcr_window_slave dcr_window_slave_chk u_chk (
  .clk(clk), .srst_n(srst_n), .dcr_addr(dcr_addr), .dcr_rd(dcr_rd),
  .dcr_wr(dcr_wr), .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .key_q(key_q)
);

// File: tb/dcr_window_slave_test.sv
module dcr_window_slave_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  dcr_addr;
  logic        dcr_rd;
  logic        dcr_wr;
  logic [31:0] dcr_wdata;
  logic [31:0] dcr_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] last_rd;

  // behavioural model state
  logic [31:0] m_key;
  int          m_idx [3];
  logic [31:0] m_mem [3][16];

  always #5 clk = ~clk;

  dcr_window_slave uut (
    .clk(clk), .rst_n(rst_n), .dcr_addr(dcr_addr), .dcr_rd(dcr_rd),
    .dcr_wr(dcr_wr), .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata)
  );

  function automatic logic [31:0] m_read(input logic [9:0] a);
    case (a)
      10'h010: return 32'(m_idx[0]);
      10'h011: return m_mem[0][m_idx[0]];
      10'h016: return 32'(m_idx[1]);
      10'h017: return m_mem[1][m_idx[1]];
      10'h020: return m_key;
      10'h021: return 32'(m_idx[2]);
      10'h022: return (m_key == 32'h49424D10) ? m_mem[2][m_idx[2]] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [9:0] a, input logic [31:0] d);
    case (a)
      10'h010: m_idx[0] = int'(d % 16);
      10'h011: m_mem[0][m_idx[0]] = d;
      10'h016: m_idx[1] = int'(d % 16);
      10'h017: m_mem[1][m_idx[1]] = d;
      10'h020: if (d != 0) m_key = (m_key == 32'h49424D10) ? 32'h49424D11 : 32'h49424D10;
      10'h021: m_idx[2] = int'(d % 16);
      10'h022: if (m_key == 32'h49424D10) m_mem[2][m_idx[2]] = d;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // called at a negative edge; one bus cycle, compared against the model
  task automatic op(input logic [9:0] a, input logic r, input logic w,
                    input logic [31:0] d, input string tag);
    logic [31:0] exp;
    dcr_addr = a; dcr_rd = r; dcr_wr = w; dcr_wdata = d;
    exp = r ? m_read(a) : 32'h0;
    if (w) m_write(a, d);
    @(posedge clk);
    #1;
    last_rd = dcr_rdata;
    check(tag, dcr_rdata, exp);
    @(negedge clk);
    dcr_rd = 1'b0; dcr_wr = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    op(a, 1'b0, 1'b1, d, tag);
  endtask

  task automatic rd_lit(input logic [9:0] a, input logic [31:0] lit, input string tag);
    op(a, 1'b1, 1'b0, 32'h0, tag);
    check(tag, last_rd, lit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    m_key = 32'h49424D11;
    for (int w = 0; w < 3; w++) begin
      m_idx[w] = 0;
      for (int e = 0; e < 16; e++) m_mem[w][e] = 32'h0;
    end
    rst_n = 1'b0; dcr_addr = '0; dcr_rd = 1'b0; dcr_wr = 1'b0; dcr_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", dcr_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_lit(10'h020, 32'h49424D11, "R1 key reset");
    rd_lit(10'h010, 32'h0, "R1 index reset");
    rd_lit(10'h017, 32'h0, "R1 entry reset");

    // R2 window A routing
    wr(10'h010, 32'd5, "R2");
    wr(10'h011, 32'hA5A50001, "R2");
    wr(10'h010, 32'd2, "R2");
    wr(10'h011, 32'h00001234, "R2");
    wr(10'h010, 32'd5, "R2");
    rd_lit(10'h011, 32'hA5A50001, "R2 entry 5");
    rd_lit(10'h010, 32'd5, "R2 index readback");

    // R3 window B independent
    wr(10'h016, 32'd15, "R3");
    wr(10'h017, 32'hDEADBEEF, "R3");
    rd_lit(10'h017, 32'hDEADBEEF, "R3 entry 15");
    rd_lit(10'h011, 32'hA5A50001, "R3 window A untouched");

    // R10 index truncation
    wr(10'h010, 32'h13, "R10");
    rd_lit(10'h010, 32'd3, "R10 index truncated");
    wr(10'h011, 32'h77, "R10");
    wr(10'h010, 32'd3, "R10");
    rd_lit(10'h011, 32'h77, "R10 entry 3");

    // R6 locked window
    wr(10'h021, 32'd4, "R6");
    rd_lit(10'h021, 32'd4, "R6 index while locked");
    wr(10'h022, 32'h0000CAFE, "R6 dropped write");
    rd_lit(10'h022, 32'h0, "R6 locked read");

    // R5 key toggle
    wr(10'h020, 32'h0, "R5 zero write");
    rd_lit(10'h020, 32'h49424D11, "R5 zero keeps key");
    wr(10'h020, 32'h1, "R5 toggle");
    rd_lit(10'h020, 32'h49424D10, "R5 key open");

    // R4 gated window usable
    rd_lit(10'h022, 32'h0, "R4 locked write was dropped");
    wr(10'h022, 32'h0000CAFE, "R4");
    rd_lit(10'h022, 32'h0000CAFE, "R4 open read");
    wr(10'h020, 32'h80000000, "R5 toggle back");
    rd_lit(10'h020, 32'h49424D11, "R5 key shut");
    rd_lit(10'h022, 32'h0, "R6 hidden again");
    wr(10'h020, 32'hFFFFFFFF, "R5");
    rd_lit(10'h022, 32'h0000CAFE, "R4 value kept");

    // R7 unmapped
    wr(10'h00C, 32'hFFFFFFFF, "R7");
    rd_lit(10'h00C, 32'h0, "R7 unmapped read");
    wr(10'h012, 32'h12345678, "R7");
    rd_lit(10'h012, 32'h0, "R7 unmapped read");
    rd_lit(10'h3FF, 32'h0, "R7 top address");
    rd_lit(10'h011, 32'h77, "R7 no side effect");

    // R8 idle gives zero
    op(10'h011, 1'b0, 1'b0, 32'h0, "R8 idle");
    check("R8 idle zero", last_rd, 32'h0);

    // R9 read and write same address
    op(10'h011, 1'b1, 1'b1, 32'h99, "R9 read old");
    check("R9 read old", last_rd, 32'h77);
    rd_lit(10'h011, 32'h99, "R9 new value");

    // mixed traffic against the model
    lfsr = 32'h1ACE5EED;
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:0])
        4'd0, 4'd1: a = 10'h010;
        4'd2:       a = 10'h011;
        4'd3:       a = 10'h016;
        4'd4:       a = 10'h017;
        4'd5:       a = 10'h020;
        4'd6, 4'd7: a = 10'h021;
        4'd8, 4'd9: a = 10'h022;
        4'd10:      a = 10'h023;
        default:    a = lfsr[13:4];
      endcase
      op(a, lfsr[14], lfsr[15], (lfsr[16] ? lfsr : 32'h0), "R2 R4 R5 R7 mixed");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule